// File: doc/BRIEF.md
# Multi-Window Converter Result Watchdog

This block watches every finished converter result as it is delivered and checks it against three independently programmed threshold windows. Each result arrives as a raw unsigned 12-bit word with a channel number, a resolution code and a one-cycle valid strobe. Before any comparison, the word is treated as left aligned, and the bit positions that the selected resolution does not produce are forced to zero.

The first watchdog is the fine one. It uses 12-bit low and high thresholds and guards either one chosen channel or every channel. The second and third watchdogs are coarse. They compare only the upper 8 bits of the shaped word against 8-bit thresholds. Each of them guards the set of channels given by a 20-bit mask, and an all-zero mask disables it.

Every watchdog keeps a sticky event flag that software clears with a write-one strobe. Each watchdog also drives an interrupt line that is gated by its own enable bit. Each flag is held by a two-state machine:

- `FLAG_QUIET` moves to `FLAG_RAISED` on a set, meaning an out-of-window result on a guarded channel.
- `FLAG_RAISED` moves back to `FLAG_QUIET` on a clear only when no set arrives in the same cycle.
- In every other case a state holds.

Top module: `conv_window_watch`

## Requirements
- R1: Resolution codes are 00 = 12-bit, 01 = 10-bit, 10 = 8-bit and 11 = 6-bit. The fine watchdog compares the raw word with its lowest 0, 2, 4 or 6 bits forced to zero for codes 00, 01, 10 and 11 respectively.
- R2: The coarse watchdogs (2 and 3) compare the top 8 bits of that shaped word. This is bits 11:4 of the raw word for codes 00, 01 and 10, and bits 11:6 followed by two zeros for code 11.
- R3: A result is out of window when the compared value is strictly above the high threshold or strictly below the low threshold. A value equal to either threshold is inside.
- R4: The fine watchdog acts only while `w1_en` is 1. With `w1_single` at 1 it guards only the channel `w1_chan`, and with `w1_single` at 0 it guards all channels.
- R5: A coarse watchdog guards channel c only when bit c of its mask is 1. A mask of all zeros disables that watchdog.
- R6: A result whose channel number is 20 or higher never sets any flag.
- R7: A flag is set on the first clock edge after an out-of-window result on a guarded channel is presented with `res_valid` at 1. Data presented while `res_valid` is 0 sets nothing.
- R8: A set flag stays set until a 1 is written to its bit of `evt_clr`. It reads 0 after the next clock edge, and clearing one bit leaves the other flags unchanged.
- R9: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: Each `irq` bit equals that watchdog's event flag ANDed with its own interrupt-enable input.
- R11: An active-low reset clears all flags, and with them all interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe, one cycle per conversion |
| res_data | input | 12 | Raw unsigned conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_mode | input | 2 | Resolution code (00 = 12, 01 = 10, 10 = 8, 11 = 6 bits) |
| w1_en | input | 1 | Fine watchdog enable |
| w1_single | input | 1 | Fine watchdog guards one channel when 1 |
| w1_chan | input | 5 | Channel guarded in single mode |
| w1_lo | input | 12 | Fine low threshold |
| w1_hi | input | 12 | Fine high threshold |
| w1_irq_en | input | 1 | Fine watchdog interrupt enable |
| w2_mask | input | 20 | Channel mask, watchdog 2 |
| w2_lo | input | 8 | Low threshold, watchdog 2 |
| w2_hi | input | 8 | High threshold, watchdog 2 |
| w2_irq_en | input | 1 | Interrupt enable, watchdog 2 |
| w3_mask | input | 20 | Channel mask, watchdog 3 |
| w3_lo | input | 8 | Low threshold, watchdog 3 |
| w3_hi | input | 8 | High threshold, watchdog 3 |
| w3_irq_en | input | 1 | Interrupt enable, watchdog 3 |
| evt_clr | input | 3 | Write-one-to-clear strobes, bit 0 = watchdog 1 |
| evt_flag | output | 3 | Sticky event flags, bit 0 = watchdog 1 |
| irq | output | 3 | Gated interrupt outputs, bit 0 = watchdog 1 |

## Verification
Each flag is one register away from the result strobe, so a flag reflects a result, or a clear, exactly one clock edge after the strobe is presented. Interrupt lines follow the flags and enables with no extra delay. The bench drives every stimulus on a falling edge and holds it for one full period. It then samples flags and interrupts on the next falling edge, which is one rising edge after the stimulus and half a period away from any edge. Cases that must leave the flags untouched are sampled at that same point, and for the invalid-strobe case a few cycles later as well.

// File: rtl/cww_pkg.sv
package cww_pkg;

    localparam int DATA_W   = 12;
    localparam int COARSE_W = 8;
    localparam int CH_W     = 5;
    localparam int NUM_CH   = 20;

    // Resolution code on the result interface
    typedef enum logic [1:0] {
        RES_FULL  = 2'b00,
        RES_TEN   = 2'b01,
        RES_EIGHT = 2'b10,
        RES_SIX   = 2'b11
    } res_mode_t;

    // Per-watchdog sticky flag state
    typedef enum logic {
        FLAG_QUIET  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;

    // Number of low-order positions that a resolution leaves unproduced
    function automatic int unsigned dropped_bits(res_mode_t m);
        int unsigned n;
        unique case (m)
            RES_FULL:  n = 0;
            RES_TEN:   n = 2;
            RES_EIGHT: n = 4;
            RES_SIX:   n = 6;
            default:   n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cww_shape.sv
// Builds the left-aligned compare words: full width and coarse top slice.
module cww_shape
    import cww_pkg::*;
#(
    parameter int DATA_W   = cww_pkg::DATA_W,
    parameter int COARSE_W = cww_pkg::COARSE_W
) (
    input  logic [DATA_W-1:0]   raw,
    input  logic [1:0]          mode,
    output logic [DATA_W-1:0]   fine_val,
    output logic [COARSE_W-1:0] coarse_val
);

    localparam int TOP = DATA_W - 1;

    logic [DATA_W-1:0] keep;
    int unsigned       drop;

    always_comb begin
        drop = dropped_bits(res_mode_t'(mode));
        for (int b = 0; b < DATA_W; b++) begin
            keep[b] = (b >= int'(drop));
        end
    end

    assign fine_val   = raw & keep;
    assign coarse_val = fine_val[TOP -: COARSE_W];

endmodule

// File: rtl/cww_decode.sv
// Channel number to one-hot guard vector; out-of-range numbers decode to zero.
module cww_decode #(
    parameter int CH_W   = cww_pkg::CH_W,
    parameter int NUM_CH = cww_pkg::NUM_CH
) (
    input  logic [CH_W-1:0]   chan,
    output logic [NUM_CH-1:0] hot
);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_hot
            assign hot[c] = (chan == CH_W'(c));
        end
    endgenerate

endmodule

// File: rtl/cww_window.sv
// Window comparison for one watchdog, qualified by strobe and guard set.
module cww_window #(
    parameter int VAL_W  = 12,
    parameter int NUM_CH = cww_pkg::NUM_CH
) (
    input  logic              valid,
    input  logic [VAL_W-1:0]  value,
    input  logic [VAL_W-1:0]  lo,
    input  logic [VAL_W-1:0]  hi,
    input  logic [NUM_CH-1:0] guard,
    input  logic [NUM_CH-1:0] chan_hot,
    output logic              hit
);

    logic guarded;
    logic above;
    logic below;

    always_comb begin
        guarded = |(guard & chan_hot);
        above   = value > hi;
        below   = value < lo;
        hit     = valid && guarded && (above || below);
    end

endmodule

// File: rtl/cww_flag.sv
// Sticky event flag as a two-state machine; a set outranks a clear.
module cww_flag
    import cww_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    flag_state_t state;
    flag_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLAG_QUIET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FLAG_QUIET:  if (set)          state_nxt = FLAG_RAISED;
            FLAG_RAISED: if (clr && !set)  state_nxt = FLAG_QUIET;
            default:                       state_nxt = FLAG_QUIET;
        endcase
    end

    always_comb begin
        flag = (state == FLAG_RAISED);
        irq  = flag && irq_en;
    end

endmodule

// File: rtl/conv_window_watch.sv
module conv_window_watch
    import cww_pkg::*;
#(
    parameter int DATA_W   = cww_pkg::DATA_W,
    parameter int COARSE_W = cww_pkg::COARSE_W,
    parameter int CH_W     = cww_pkg::CH_W,
    parameter int NUM_CH   = cww_pkg::NUM_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [DATA_W-1:0]   res_data,
    input  logic [CH_W-1:0]     res_chan,
    input  logic [1:0]          res_mode,
    input  logic                w1_en,
    input  logic                w1_single,
    input  logic [CH_W-1:0]     w1_chan,
    input  logic [DATA_W-1:0]   w1_lo,
    input  logic [DATA_W-1:0]   w1_hi,
    input  logic                w1_irq_en,
    input  logic [NUM_CH-1:0]   w2_mask,
    input  logic [COARSE_W-1:0] w2_lo,
    input  logic [COARSE_W-1:0] w2_hi,
    input  logic                w2_irq_en,
    input  logic [NUM_CH-1:0]   w3_mask,
    input  logic [COARSE_W-1:0] w3_lo,
    input  logic [COARSE_W-1:0] w3_hi,
    input  logic                w3_irq_en,
    input  logic [2:0]          evt_clr,
    output logic [2:0]          evt_flag,
    output logic [2:0]          irq
);

    localparam int NUM_WD     = 3;
    localparam int NUM_COARSE = NUM_WD - 1;

    logic [DATA_W-1:0]   fine_val;
    logic [COARSE_W-1:0] coarse_val;
    logic [NUM_CH-1:0]   res_hot;
    logic [NUM_CH-1:0]   w1_hot;
    logic [NUM_CH-1:0]   w1_guard;
    logic [NUM_WD-1:0]   hit;
    logic [NUM_WD-1:0]   irq_en_vec;

    logic [COARSE_W-1:0] c_lo   [NUM_COARSE];
    logic [COARSE_W-1:0] c_hi   [NUM_COARSE];
    logic [NUM_CH-1:0]   c_mask [NUM_COARSE];

    cww_shape #(
        .DATA_W   (DATA_W),
        .COARSE_W (COARSE_W)
    ) u_shape (
        .raw        (res_data),
        .mode       (res_mode),
        .fine_val   (fine_val),
        .coarse_val (coarse_val)
    );

    cww_decode #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_res_dec (
        .chan (res_chan),
        .hot  (res_hot)
    );

    cww_decode #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_sel_dec (
        .chan (w1_chan),
        .hot  (w1_hot)
    );

    // Fine watchdog guard set: nothing, one channel, or all channels
    always_comb begin
        if (!w1_en) begin
            w1_guard = '0;
        end else if (w1_single) begin
            w1_guard = w1_hot;
        end else begin
            w1_guard = '1;
        end
    end

    cww_window #(.VAL_W(DATA_W), .NUM_CH(NUM_CH)) u_win_fine (
        .valid    (res_valid),
        .value    (fine_val),
        .lo       (w1_lo),
        .hi       (w1_hi),
        .guard    (w1_guard),
        .chan_hot (res_hot),
        .hit      (hit[0])
    );

    always_comb begin
        c_lo[0]   = w2_lo;
        c_hi[0]   = w2_hi;
        c_mask[0] = w2_mask;
        c_lo[1]   = w3_lo;
        c_hi[1]   = w3_hi;
        c_mask[1] = w3_mask;
    end

    generate
        for (genvar k = 0; k < NUM_COARSE; k++) begin : g_coarse
            cww_window #(.VAL_W(COARSE_W), .NUM_CH(NUM_CH)) u_win (
                .valid    (res_valid),
                .value    (coarse_val),
                .lo       (c_lo[k]),
                .hi       (c_hi[k]),
                .guard    (c_mask[k]),
                .chan_hot (res_hot),
                .hit      (hit[k+1])
            );
        end
    endgenerate

    assign irq_en_vec = {w3_irq_en, w2_irq_en, w1_irq_en};

    generate
        for (genvar w = 0; w < NUM_WD; w++) begin : g_flag
            cww_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set    (hit[w]),
                .clr    (evt_clr[w]),
                .irq_en (irq_en_vec[w]),
                .flag   (evt_flag[w]),
                .irq    (irq[w])
            );
        end
    endgenerate

endmodule

// File: rtl/cww_checker.sv
module cww_checker #(
    parameter int CH_W   = 5,
    parameter int NUM_CH = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [CH_W-1:0]   res_chan,
    input logic              w1_en,
    input logic [NUM_CH-1:0] w2_mask,
    input logic [NUM_CH-1:0] w3_mask,
    input logic              w1_irq_en,
    input logic              w2_irq_en,
    input logic              w3_irq_en,
    input logic [2:0]        evt_clr,
    input logic [2:0]        evt_flag,
    input logic [2:0]        irq
);

    logic [2:0] ien;
    assign ien = {w3_irq_en, w2_irq_en, w1_irq_en};

    generate
        for (genvar i = 0; i < 3; i++) begin : g_wd
            a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                evt_flag[i] && !evt_clr[i] |=> evt_flag[i]);

            a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
                evt_clr[i] && !res_valid |=> !evt_flag[i]);

            a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                !res_valid && !evt_flag[i] |=> !evt_flag[i]);

            a_r6_far_channel: assert property (@(posedge clk) disable iff (!rst_n)
                res_chan >= CH_W'(NUM_CH) && !evt_flag[i] |=> !evt_flag[i]);

            a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> (evt_flag[i] && ien[i]));
        end
    endgenerate

    a_r4_fine_off: assert property (@(posedge clk) disable iff (!rst_n)
        !w1_en && !evt_flag[0] |=> !evt_flag[0]);

    a_r5_empty_mask2: assert property (@(posedge clk) disable iff (!rst_n)
        w2_mask == '0 && !evt_flag[1] |=> !evt_flag[1]);

    a_r5_empty_mask3: assert property (@(posedge clk) disable iff (!rst_n)
        w3_mask == '0 && !evt_flag[2] |=> !evt_flag[2]);

endmodule

bind conv_window_watch cww_checker #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .w1_en     (w1_en),
    .w2_mask   (w2_mask),
    .w3_mask   (w3_mask),
    .w1_irq_en (w1_irq_en),
    .w2_irq_en (w2_irq_en),
    .w3_irq_en (w3_irq_en),
    .evt_clr   (evt_clr),
    .evt_flag  (evt_flag),
    .irq       (irq)
);

// File: tb/conv_window_watch_tb.sv
module conv_window_watch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic [1:0]  res_mode = '0;
    logic        w1_en = 1'b0, w1_single = 1'b0, w1_irq_en = 1'b0;
    logic [4:0]  w1_chan = '0;
    logic [11:0] w1_lo = '0, w1_hi = '0;
    logic [19:0] w2_mask = '0, w3_mask = '0;
    logic [7:0]  w2_lo = '0, w2_hi = '0, w3_lo = '0, w3_hi = '0;
    logic        w2_irq_en = 1'b0, w3_irq_en = 1'b0;
    logic [2:0]  evt_clr = '0;
    logic [2:0]  evt_flag, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    conv_window_watch u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_mode(res_mode), .w1_en(w1_en),
        .w1_single(w1_single), .w1_chan(w1_chan), .w1_lo(w1_lo), .w1_hi(w1_hi),
        .w1_irq_en(w1_irq_en), .w2_mask(w2_mask), .w2_lo(w2_lo), .w2_hi(w2_hi),
        .w2_irq_en(w2_irq_en), .w3_mask(w3_mask), .w3_lo(w3_lo), .w3_hi(w3_hi),
        .w3_irq_en(w3_irq_en), .evt_clr(evt_clr), .evt_flag(evt_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Present one strobed result; returns one rising edge later, on a falling edge
    task automatic put(input logic [11:0] d, input logic [4:0] ch, input logic [1:0] m);
        @(negedge clk);
        res_valid = 1'b1; res_data = d; res_chan = ch; res_mode = m;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic clr(input logic [2:0] which);
        @(negedge clk);
        evt_clr = which;
        @(negedge clk);
        evt_clr = '0;
    endtask

    task automatic cfg_off;
        w1_en = 0; w1_single = 0; w1_chan = 0; w1_lo = 0; w1_hi = 12'hFFF;
        w2_mask = 0; w3_mask = 0; w2_lo = 0; w2_hi = 8'hFF; w3_lo = 0; w3_hi = 8'hFF;
        w1_irq_en = 0; w2_irq_en = 0; w3_irq_en = 0;
        clr(3'b111);
    endtask

    task automatic t_reset;
        chk("R11", "flags after reset", evt_flag, 3'b000);
        chk("R11", "irq after reset", irq, 3'b000);
    endtask

    task automatic t_r3_bounds;
        cfg_off();
        w1_en = 1; w1_lo = 12'd100; w1_hi = 12'd200;
        put(12'd200, 5'd3, 2'b00); chk("R3", "equal high inside", evt_flag, 3'b000);
        put(12'd201, 5'd3, 2'b00); chk("R3", "one above high", evt_flag, 3'b001);
        clr(3'b001);
        put(12'd100, 5'd3, 2'b00); chk("R3", "equal low inside", evt_flag, 3'b000);
        put(12'd99, 5'd3, 2'b00);  chk("R3", "one below low", evt_flag, 3'b001);
    endtask

    task automatic t_r1_fine_shape;
        cfg_off();
        w1_en = 1; w1_lo = 12'h000; w1_hi = 12'h0C8;
        put(12'h0CB, 5'd1, 2'b01); chk("R1", "10-bit drops two bits", evt_flag, 3'b000);
        put(12'h0CB, 5'd1, 2'b00); chk("R1", "12-bit keeps all bits", evt_flag, 3'b001);
        clr(3'b001);
        w1_hi = 12'h0C0;
        put(12'h0CF, 5'd1, 2'b10); chk("R1", "8-bit drops four bits", evt_flag, 3'b000);
        put(12'h0CF, 5'd1, 2'b01); chk("R1", "10-bit over 0C0", evt_flag, 3'b001);
        clr(3'b001);
        w1_lo = 12'h040; w1_hi = 12'hFC0;
        put(12'h07F, 5'd1, 2'b11); chk("R1", "6-bit floors to low", evt_flag, 3'b000);
        put(12'h03F, 5'd1, 2'b11); chk("R1", "6-bit below low", evt_flag, 3'b001);
    endtask

    task automatic t_r2_coarse_shape;
        cfg_off();
        w2_mask = '1; w3_mask = '1; w2_lo = 8'h04; w2_hi = 8'h0C; w3_lo = 8'h04; w3_hi = 8'h0C;
        put(12'h0CF, 5'd0, 2'b00); chk("R2", "top byte equals high", evt_flag, 3'b000);
        put(12'h0D0, 5'd0, 2'b00); chk("R2", "top byte above high", evt_flag, 3'b110);
        clr(3'b110);
        put(12'h0F0, 5'd0, 2'b11); chk("R2", "6-bit top byte 0C", evt_flag, 3'b000);
        put(12'h0F0, 5'd0, 2'b10); chk("R2", "8-bit top byte 0F", evt_flag, 3'b110);
        clr(3'b110);
        put(12'h040, 5'd0, 2'b11); chk("R2", "6-bit equal low", evt_flag, 3'b000);
        put(12'h03F, 5'd0, 2'b11); chk("R2", "6-bit below low", evt_flag, 3'b110);
    endtask

    task automatic t_r4_select;
        cfg_off();
        w1_en = 1; w1_single = 1; w1_chan = 5'd5; w1_lo = 12'd100; w1_hi = 12'd200;
        put(12'h300, 5'd6, 2'b00); chk("R4", "other channel ignored", evt_flag, 3'b000);
        put(12'h300, 5'd5, 2'b00); chk("R4", "selected channel", evt_flag, 3'b001);
        clr(3'b001);
        w1_single = 0;
        put(12'h300, 5'd19, 2'b00); chk("R4", "all channels mode", evt_flag, 3'b001);
        clr(3'b001);
        w1_en = 0;
        put(12'h300, 5'd5, 2'b00); chk("R4", "disabled", evt_flag, 3'b000);
    endtask

    task automatic t_r5_mask;
        cfg_off();
        w3_mask = 20'h00080; w3_lo = 8'h10; w3_hi = 8'h20;
        put(12'hFFF, 5'd8, 2'b00); chk("R5", "unmasked channel", evt_flag, 3'b000);
        put(12'hFFF, 5'd7, 2'b00); chk("R5", "masked channel 7", evt_flag, 3'b100);
        clr(3'b100);
        w3_mask = '0;
        put(12'hFFF, 5'd7, 2'b00); chk("R5", "empty mask", evt_flag, 3'b000);
        w2_mask = 20'h80000; w2_lo = 8'h10; w2_hi = 8'h20;
        put(12'hFFF, 5'd19, 2'b00); chk("R5", "mask bit 19", evt_flag, 3'b010);
    endtask

    task automatic cfg_all_trip;
        cfg_off();
        w1_en = 1; w1_hi = 12'h000; w2_mask = '1; w2_hi = 8'h00; w3_mask = '1; w3_hi = 8'h00;
    endtask

    task automatic t_r6_far;
        cfg_all_trip();
        put(12'hFFF, 5'd20, 2'b00); chk("R6", "channel 20", evt_flag, 3'b000);
        put(12'hFFF, 5'd31, 2'b00); chk("R6", "channel 31", evt_flag, 3'b000);
        put(12'hFFF, 5'd0, 2'b00);  chk("R6", "channel 0 trips", evt_flag, 3'b111);
    endtask

    task automatic t_r7_strobe;
        cfg_all_trip();
        @(negedge clk);
        res_valid = 0; res_data = 12'hFFF; res_chan = 5'd0; res_mode = 2'b00;
        @(negedge clk); chk("R7", "no strobe one cycle", evt_flag, 3'b000);
        repeat (3) @(negedge clk);
        chk("R7", "no strobe later", evt_flag, 3'b000);
    endtask

    task automatic t_r8_sticky;
        cfg_all_trip();
        put(12'hFFF, 5'd2, 2'b00);
        repeat (5) @(negedge clk);
        chk("R8", "held without clear", evt_flag, 3'b111);
        clr(3'b010); chk("R8", "clear only watchdog 2", evt_flag, 3'b101);
        clr(3'b101); chk("R8", "clear the rest", evt_flag, 3'b000);
    endtask

    task automatic t_r9_set_wins;
        cfg_all_trip();
        put(12'hFFF, 5'd2, 2'b00);
        @(negedge clk);
        res_valid = 1; res_data = 12'hFFF; res_chan = 5'd2; evt_clr = 3'b111;
        @(negedge clk);
        res_valid = 0; evt_clr = 3'b000;
        chk("R9", "set beats clear", evt_flag, 3'b111);
    endtask

    task automatic t_r10_irq;
        cfg_all_trip();
        put(12'hFFF, 5'd2, 2'b00);
        w1_irq_en = 1; w2_irq_en = 0; w3_irq_en = 1;
        @(negedge clk); chk("R10", "irq enables 101", irq, 3'b101);
        w1_irq_en = 0; w2_irq_en = 1; w3_irq_en = 0;
        @(negedge clk); chk("R10", "irq enables 010", irq, 3'b010);
        w1_irq_en = 1; w3_irq_en = 1;
        clr(3'b111); chk("R10", "irq after clear", irq, 3'b000);
    endtask

    task automatic t_r11_midreset;
        cfg_all_trip();
        w1_irq_en = 1; w2_irq_en = 1; w3_irq_en = 1;
        put(12'hFFF, 5'd2, 2'b00);
        chk("R11", "flags before reset", evt_flag, 3'b111);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk("R11", "flags in reset", evt_flag, 3'b000);
        chk("R11", "irq in reset", irq, 3'b000);
        rst_n = 1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL all: watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_r3_bounds();
        t_r1_fine_shape();
        t_r2_coarse_shape();
        t_r4_select();
        t_r5_mask();
        t_r6_far();
        t_r7_strobe();
        t_r8_sticky();
        t_r9_set_wins();
        t_r10_irq();
        t_r11_midreset();
        finish_run();
    end

endmodule